// File: doc/BRIEF.md
# Processor Data Bus Steering Controller

This block sits between a processor core's memory-cycle control and the data pins of the chip. A static mode input selects one of two bus arrangements. In shared mode, a single bidirectional bus carries both read and store data through a tristate buffer. In split mode, read data arrives on a dedicated input bus and store data leaves on a dedicated output bus, and the bidirectional pins are never driven.

The core asks for a write one cycle in advance. The block raises a write indicator for the announcing cycle. It then opens a one-cycle store window, in which the store data register is loaded and launched. The block marks the window with an active-low output-enable status.

The actual drive of the shared pins is the AND of four terms:
- the internal write window,
- an active-low external enable that can delay or block driving,
- an active-high legacy data enable,
- an active-low test enable.

The test enable also floats the address and control outputs. It acts combinationally, with no register in its path. Every high-impedance control is given as an output-enable flag.

Top module: `dbs_steer_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block returns to this state: `wr_ind` 0, `out_en_n` 1, `drive_en` 0, `pin_dout` 0, `split_out` 0 and `rd_data` 0.
- R2: `wr_ind` is high in the cycle that follows each edge at which `wr_req` is sampled high. It is low after an edge at which `wr_req` is low.
- R3: The cycle after a `wr_ind` cycle is a store cycle. In shared mode (`split_mode`=0), `out_en_n` is low for exactly the store cycles. It returns high at the edge that ends the last consecutive store cycle.
- R4: `core_wdata` is captured at the edge that starts a store cycle. It appears on `pin_dout` throughout that store cycle, and each back-to-back store carries its own word.
- R5: `drive_en` is 1 only in a shared-mode store cycle while `ext_en_n`=0, `dbus_en`=1 and `test_en_n`=1. Any one of these enables being inactive removes drive in the same cycle.
- R6: `test_en_n`=0 forces `drive_en` and `addr_oe` to 0 in the same cycle, without waiting for a clock edge.
- R7: `addr_oe` is 1 exactly when `addr_en`=1 and `test_en_n`=1.
- R8: In split mode (`split_mode`=1), `split_out` shows the stored word from the edge that starts each store cycle. Between store cycles it holds its value. `out_en_n` stays 1 and `drive_en` stays 0.
- R9: In shared mode, `split_out` is 0 whatever the store data.
- R10: At each edge that ends a cycle other than a store cycle, `rd_data` captures the selected bus: `split_in` in split mode, `bidir_in` in shared mode. The unselected bus is ignored. Across a store cycle, `rd_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each rising edge is a bus phase boundary |
| rst_n | input | 1 | Synchronous active-low reset |
| split_mode | input | 1 | Static bus mode: 1 split buses, 0 shared bidirectional bus |
| wr_req | input | 1 | Core announces that the cycle after next is a store |
| core_wdata | input | DW | Store data from the core, valid in the announcing cycle |
| bidir_in | input | DW | Value seen on the shared pins |
| split_in | input | DW | Dedicated read-data bus |
| ext_en_n | input | 1 | Active-low external drive enable |
| dbus_en | input | 1 | Legacy data-bus enable, active high |
| addr_en | input | 1 | Address/control output enable, active high |
| test_en_n | input | 1 | Active-low test enable that floats all tristatable outputs |
| wr_ind | output | 1 | Write indicator, high in the cycle before a store |
| out_en_n | output | 1 | Active-low status: block owns the shared bus |
| drive_en | output | 1 | Tristate buffer enable for the shared pins |
| pin_dout | output | DW | Data toward the shared pins |
| split_out | output | DW | Dedicated store-data bus |
| rd_data | output | DW | Captured read data |
| addr_oe | output | 1 | Output enable for address and control pins |

## Verification
`wr_ind` is due one edge after `wr_req` is sampled. The store window, `out_en_n`, `pin_dout` and `split_out` follow one edge later, two edges after the request. `rd_data` is due one edge after the bus value is presented. `drive_en` and `addr_oe` settle within the same cycle in which an enable input changes.

The bench drives inputs at falling edges and reads registered results at the next falling edge, half a period after the edge that updates them. It reads combinational results 1 ns after the input change, with the clock held still.

// File: rtl/dbs_pkg.sv
// Shared types for the data bus steering controller.
package dbs_pkg;
    // Bus arrangement selected by the static mode input.
    typedef enum logic {
        BUS_SHARED = 1'b0,
        BUS_SPLIT  = 1'b1
    } bus_mode_e;
endpackage

// File: rtl/dbs_phase_seq.sv
// Write-phase sequencer.
// Turns a one-cycle-ahead write request into the write indicator and then
// into the store window one cycle later.
// Assumes: wr_req is sampled at every rising edge; synchronous active-low reset.
module dbs_phase_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_req,
    output logic wr_ind,
    output logic store_cyc
);
    logic ind_q;
    logic cyc_q;

    // Advance the request through the announce and store phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ind_q <= 1'b0;
            cyc_q <= 1'b0;
        end else begin
            ind_q <= wr_req;
            cyc_q <= ind_q;
        end
    end

    assign wr_ind    = ind_q;
    assign store_cyc = cyc_q;
endmodule

// File: rtl/dbs_data_path.sv
// Data path: the store data register, the read capture register and the
// split-bus output forcing.
// Assumes: mode is static between resets; load is high during the announce
// cycle, so the capture coincides with the start of the store cycle.
module dbs_data_path
    import dbs_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bus_mode_e     mode,
    input  logic          load,
    input  logic          store_cyc,
    input  logic [DW-1:0] core_wdata,
    input  logic [DW-1:0] bidir_in,
    input  logic [DW-1:0] split_in,
    output logic [DW-1:0] pin_dout,
    output logic [DW-1:0] split_out,
    output logic [DW-1:0] rd_data
);
    localparam logic [DW-1:0] ZERO = '0;

    logic [DW-1:0] st_q;
    logic [DW-1:0] rd_q;
    logic [DW-1:0] rd_sel;

    // Select the read source according to the bus mode.
    always_comb begin
        rd_sel = (mode == BUS_SPLIT) ? split_in : bidir_in;
    end

    // Launch store data at the edge that opens the store cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ZERO;
        end else if (load) begin
            st_q <= core_wdata;
        end
    end

    // Capture read data at every edge that does not end a store cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= ZERO;
        end else if (!store_cyc) begin
            rd_q <= rd_sel;
        end
    end

    assign pin_dout  = st_q;
    assign split_out = (mode == BUS_SPLIT) ? st_q : ZERO;
    assign rd_data   = rd_q;
endmodule

// File: rtl/dbs_enable_gate.sv
// Enable gating.
// Combines the internal store window with the external, legacy and test
// enables into the pin drive and output-enable flags.
// Assumes: the test enable has no register in its path, so it acts at once.
module dbs_enable_gate
    import dbs_pkg::*;
(
    input  bus_mode_e mode,
    input  logic      store_cyc,
    input  logic      ext_en_n,
    input  logic      dbus_en,
    input  logic      addr_en,
    input  logic      test_en_n,
    output logic      out_en_n,
    output logic      drive_en,
    output logic      addr_oe
);
    logic own_bus;

    // The core owns the shared bus only in a shared-mode store cycle.
    always_comb begin
        own_bus  = store_cyc && (mode == BUS_SHARED);
        out_en_n = !own_bus;
        drive_en = own_bus && !ext_en_n && dbus_en && test_en_n;
        addr_oe  = addr_en && test_en_n;
    end
endmodule

// File: rtl/dbs_steer_ctrl.sv
// Top of the data bus steering controller.
// Chooses between a shared bidirectional data bus and split in/out buses.
// Sequences the write phases and gates the pin drive.
// Assumes: split_mode changes only under reset.
module dbs_steer_ctrl
    import dbs_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          split_mode,
    input  logic          wr_req,
    input  logic [DW-1:0] core_wdata,
    input  logic [DW-1:0] bidir_in,
    input  logic [DW-1:0] split_in,
    input  logic          ext_en_n,
    input  logic          dbus_en,
    input  logic          addr_en,
    input  logic          test_en_n,
    output logic          wr_ind,
    output logic          out_en_n,
    output logic          drive_en,
    output logic [DW-1:0] pin_dout,
    output logic [DW-1:0] split_out,
    output logic [DW-1:0] rd_data,
    output logic          addr_oe
);
    bus_mode_e mode;
    logic      store_cyc;

    assign mode = split_mode ? BUS_SPLIT : BUS_SHARED;

    dbs_phase_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (wr_req),
        .wr_ind    (wr_ind),
        .store_cyc (store_cyc)
    );

    dbs_data_path #(.DW(DW)) u_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .load       (wr_ind),
        .store_cyc  (store_cyc),
        .core_wdata (core_wdata),
        .bidir_in   (bidir_in),
        .split_in   (split_in),
        .pin_dout   (pin_dout),
        .split_out  (split_out),
        .rd_data    (rd_data)
    );

    dbs_enable_gate u_gate (
        .mode      (mode),
        .store_cyc (store_cyc),
        .ext_en_n  (ext_en_n),
        .dbus_en   (dbus_en),
        .addr_en   (addr_en),
        .test_en_n (test_en_n),
        .out_en_n  (out_en_n),
        .drive_en  (drive_en),
        .addr_oe   (addr_oe)
    );
endmodule

// File: rtl/dbs_steer_ctrl_chk.sv
// Checker for the data bus steering controller. It observes only the top
// ports and is attached with the bind below.
module dbs_steer_ctrl_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          split_mode,
    input logic          wr_req,
    input logic          ext_en_n,
    input logic          dbus_en,
    input logic          addr_en,
    input logic          test_en_n,
    input logic          wr_ind,
    input logic          out_en_n,
    input logic          drive_en,
    input logic [DW-1:0] split_out,
    input logic [DW-1:0] rd_data,
    input logic          addr_oe
);
    p_wr_ind_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> wr_ind);

    p_store_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ind && !split_mode) |=> !out_en_n);

    p_oe_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ind |=> out_en_n);

    p_drive_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> (!out_en_n && !ext_en_n && dbus_en && test_en_n));

    p_test_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en_n |-> (!drive_en && !addr_oe));

    p_addr_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_en && test_en_n) |-> addr_oe);

    p_split_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (split_mode && !wr_ind) |=> $stable(split_out));

    p_split_no_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        split_mode |-> (out_en_n && !drive_en));

    p_shared_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !split_mode |-> (split_out == '0));

    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en_n |=> $stable(rd_data));
endmodule

bind dbs_steer_ctrl dbs_steer_ctrl_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .split_mode (split_mode),
    .wr_req     (wr_req),
    .ext_en_n   (ext_en_n),
    .dbus_en    (dbus_en),
    .addr_en    (addr_en),
    .test_en_n  (test_en_n),
    .wr_ind     (wr_ind),
    .out_en_n   (out_en_n),
    .drive_en   (drive_en),
    .split_out  (split_out),
    .rd_data    (rd_data),
    .addr_oe    (addr_oe)
);

// File: tb/dbs_steer_ctrl_bench.sv
// Directed bench: inputs change at falling edges. Registered results are read
// at the next falling edge; combinational results 1 ns after an input change.
module dbs_steer_ctrl_bench;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          split_mode;
    logic          wr_req;
    logic [DW-1:0] core_wdata;
    logic [DW-1:0] bidir_in;
    logic [DW-1:0] split_in;
    logic          ext_en_n;
    logic          dbus_en;
    logic          addr_en;
    logic          test_en_n;
    logic          wr_ind;
    logic          out_en_n;
    logic          drive_en;
    logic [DW-1:0] pin_dout;
    logic [DW-1:0] split_out;
    logic [DW-1:0] rd_data;
    logic          addr_oe;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    dbs_steer_ctrl #(.DW(DW)) u_dbs_steer_ctrl (
        .clk(clk), .rst_n(rst_n), .split_mode(split_mode), .wr_req(wr_req),
        .core_wdata(core_wdata), .bidir_in(bidir_in), .split_in(split_in),
        .ext_en_n(ext_en_n), .dbus_en(dbus_en), .addr_en(addr_en),
        .test_en_n(test_en_n), .wr_ind(wr_ind), .out_en_n(out_en_n),
        .drive_en(drive_en), .pin_dout(pin_dout), .split_out(split_out),
        .rd_data(rd_data), .addr_oe(addr_oe)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply_reset(input logic mode);
        @(negedge clk);
        rst_n = 1'b0; split_mode = mode; wr_req = 1'b0;
        core_wdata = '0; bidir_in = '0; split_in = '0;
        ext_en_n = 1'b0; dbus_en = 1'b1; addr_en = 1'b1; test_en_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Announce a store and return at the falling edge inside its store cycle.
    task automatic do_write(input logic [DW-1:0] data);
        wr_req = 1'b1; core_wdata = data;
        @(negedge clk);
        check("R2 wr_ind after request", {31'b0, wr_ind}, 1);
        wr_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        apply_reset(1'b0);
        check("R1 wr_ind", {31'b0, wr_ind}, 0);
        check("R1 out_en_n", {31'b0, out_en_n}, 1);
        check("R1 drive_en", {31'b0, drive_en}, 0);
        check("R1 pin_dout", pin_dout, 0);
        check("R1 split_out", split_out, 0);
        check("R1 rd_data", rd_data, 0);
    endtask

    task automatic t_shared_write;
        apply_reset(1'b0);
        check("R2 wr_ind idle", {31'b0, wr_ind}, 0);
        do_write(32'hCAFE_0123);
        check("R3 out_en_n low in store", {31'b0, out_en_n}, 0);
        check("R4 pin_dout", pin_dout, 32'hCAFE_0123);
        check("R5 drive_en", {31'b0, drive_en}, 1);
        check("R9 split_out zero", split_out, 0);
        @(negedge clk);
        check("R3 out_en_n release", {31'b0, out_en_n}, 1);
        check("R5 drive off after store", {31'b0, drive_en}, 0);
        check("R2 wr_ind low", {31'b0, wr_ind}, 0);
    endtask

    task automatic t_enables;
        apply_reset(1'b0);
        ext_en_n = 1'b1;
        do_write(32'h1234_5678);
        check("R5 ext_en_n blocks", {31'b0, drive_en}, 0);
        check("R3 status still low", {31'b0, out_en_n}, 0);
        ext_en_n = 1'b0; dbus_en = 1'b0; #1;
        check("R5 dbus_en blocks", {31'b0, drive_en}, 0);
        dbus_en = 1'b1; test_en_n = 1'b0; #1;
        check("R6 test drive", {31'b0, drive_en}, 0);
        check("R6 test addr", {31'b0, addr_oe}, 0);
        test_en_n = 1'b1; #1;
        check("R5 all enables", {31'b0, drive_en}, 1);
        check("R7 addr_oe on", {31'b0, addr_oe}, 1);
        addr_en = 1'b0; #1;
        check("R7 addr_oe off", {31'b0, addr_oe}, 0);
        addr_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_shared_read;
        apply_reset(1'b0);
        bidir_in = 32'hAAAA_0001; split_in = 32'h5555_0002;
        @(negedge clk);
        check("R10 shared read", rd_data, 32'hAAAA_0001);
        do_write(32'h0BAD_F00D);
        bidir_in = 32'hDEAD_0003;
        @(negedge clk);
        check("R10 hold over store", rd_data, 32'hAAAA_0001);
        @(negedge clk);
        check("R10 capture after store", rd_data, 32'hDEAD_0003);
    endtask

    task automatic t_split;
        apply_reset(1'b1);
        do_write(32'hB0B0_1111);
        check("R8 split_out store", split_out, 32'hB0B0_1111);
        check("R8 no status", {31'b0, out_en_n}, 1);
        check("R8 no drive", {31'b0, drive_en}, 0);
        split_in = 32'h7777_0004; bidir_in = 32'h3333_0005; core_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        @(negedge clk);
        check("R10 split read", rd_data, 32'h7777_0004);
        check("R8 split_out holds", split_out, 32'hB0B0_1111);
        do_write(32'hC0C0_2222);
        check("R8 split_out second", split_out, 32'hC0C0_2222);
    endtask

    task automatic t_back_to_back;
        apply_reset(1'b0);
        wr_req = 1'b1; core_wdata = 32'hD1D1_D1D1;
        @(negedge clk);
        @(negedge clk);
        wr_req = 1'b0; core_wdata = 32'hD2D2_D2D2;
        check("R4 first word", pin_dout, 32'hD1D1_D1D1);
        check("R3 first store", {31'b0, out_en_n}, 0);
        @(negedge clk);
        check("R4 second word", pin_dout, 32'hD2D2_D2D2);
        check("R3 second store", {31'b0, out_en_n}, 0);
        @(negedge clk);
        check("R3 release after pair", {31'b0, out_en_n}, 1);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_shared_write();
        t_enables();
        t_shared_read();
        t_split();
        t_back_to_back();
        finish_run();
    end

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule